// File: doc/BRIEF.md
# Warp Load Address Coalescer

This block takes a single load request from a warp of threads: one byte address per thread lane, plus a mask marking which lanes are active. It groups the active addresses by the aligned memory segment they fall in and produces one memory transaction for each distinct segment the warp touches. Accesses that coalesce therefore need far fewer transactions than there are threads.

Each transaction carries two things. The first is the segment base address. The second is a lane mask that lists exactly the threads served by that segment, so that data coming back from memory can be steered to the right lanes. Transactions leave one per cycle on a valid/ready port. The ordering rule is fixed: the next transaction is always the segment of the lowest-numbered lane that is still unserved.

A new warp is taken in only after every transaction of the current warp has been handed off. A warp whose lanes are all inactive is absorbed and produces no transactions. Each lane access is a 4-byte word.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, tx_valid is low and in_ready is high.
- R2: in_ready is low whenever transactions of an accepted warp remain to be emitted. A request presented during that time is not taken.
- R3: tx_base equals the leading lane's address with its low log2(SEG_BYTES) bits (7 bits for 128-byte segments) cleared.
- R4: tx_mask bit i is set exactly when lane i is active, not yet served, and its address lies in the same aligned segment as the leading lane.
- R5: The leading lane of each transaction is the lowest-numbered active lane not served by an earlier transaction of the same warp.
- R6: Lanes whose in_mask bit is 0 never appear in any tx_mask, whatever their address.
- R7: A warp with in_mask all zero produces no transaction, and the block is ready again on the next cycle.
- R8: Sixteen lanes loading consecutive 4-byte words inside one segment produce exactly one transaction.
- R9: Lanes whose addresses stride by a full segment or more produce one transaction per active lane.
- R10: tx_last is high on the final transaction of a warp and low on every earlier one.
- R11: While tx_valid is high and tx_ready is low, tx_valid, tx_base and tx_mask hold their values.
- R12: Across one warp the transaction masks are disjoint, and their union equals in_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Warp request present |
| in_ready | output | 1 | Block idle and able to take a warp |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses; lane i occupies bits [i*ADDR_W +: ADDR_W] |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| tx_valid | output | 1 | Transaction present |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_base | output | ADDR_W | Aligned segment base address |
| tx_mask | output | LANES | Lanes served by this transaction |
| tx_last | output | 1 | Final transaction of the current warp |

## Verification
The bench builds the block with its defaults: 32 lanes, 32-bit addresses and 128-byte segments. With these values a single warp can span anything from one segment to 32 distinct segments, so the fully coalesced case, the half-warp case and the fully scattered row-stride case can all be driven. The defaults also allow a misaligned run that straddles a segment edge and an interleaved pattern in which leading lanes are chosen out of address order. A stalled downstream port exercises the hold and busy rules.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;
endpackage

// File: rtl/coal_lead_pick.sv
// Finds the lowest-numbered pending lane as a one-hot vector.
module coal_lead_pick #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] req,
    output logic [LANES-1:0] oh,
    output logic             any
);
    logic [LANES-1:0] seen;

    always_comb begin
        oh   = '0;
        seen = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i == 0) begin
                oh[i]   = req[i];
                seen[i] = req[i];
            end else begin
                oh[i]   = req[i] & ~seen[i-1];
                seen[i] = req[i] | seen[i-1];
            end
        end
        any = seen[LANES-1];
    end

    always_comb begin
        AST_LEAD_ONEHOT: assert ($onehot0(oh)); // R5
    end
endmodule

// File: rtl/coal_seg_match.sv
// Marks every pending lane whose address shares the leader's segment.
module coal_seg_match #(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0]       lead_addr,
    input  logic [LANES-1:0]        pend,
    output logic [LANES-1:0]        hit
);
    localparam int SEG_LSB = $clog2(SEG_BYTES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] diff;
        assign diff   = addr[g*ADDR_W +: ADDR_W] ^ lead_addr;
        assign hit[g] = pend[g] && (diff[ADDR_W-1:SEG_LSB] == '0);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_mask,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [ADDR_W-1:0]       tx_base,
    output logic [LANES-1:0]        tx_mask,
    output logic                    tx_last
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(SEG_BYTES - 1);

    typedef struct packed {
        phase_e                  phase;
        logic [LANES-1:0]        pend;
        logic [LANES*ADDR_W-1:0] addr;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]  lead_oh;
    logic              lead_any;
    logic [ADDR_W-1:0] lead_addr;
    logic [LANES-1:0]  hit;

    coal_lead_pick #(.LANES(LANES)) u_pick (
        .req (st_q.pend),
        .oh  (lead_oh),
        .any (lead_any)
    );

    always_comb begin
        lead_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lead_oh[i]) lead_addr = lead_addr | st_q.addr[i*ADDR_W +: ADDR_W];
        end
    end

    coal_seg_match #(
        .LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)
    ) u_match (
        .addr      (st_q.addr),
        .lead_addr (lead_addr),
        .pend      (st_q.pend),
        .hit       (hit)
    );

    assign in_ready = (st_q.phase == PH_IDLE);
    assign tx_valid = (st_q.phase == PH_EMIT) && lead_any;
    assign tx_base  = lead_addr & ~OFS_MASK;
    assign tx_mask  = hit;
    assign tx_last  = tx_valid && ((st_q.pend & ~hit) == '0);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    st_d.addr  = in_addr;
                    st_d.pend  = in_mask;
                    st_d.phase = (in_mask != '0) ? PH_EMIT : PH_IDLE;
                end
            end
            PH_EMIT: begin
                if (tx_ready) begin
                    st_d.pend = st_q.pend & ~hit;
                    if (tx_last || !lead_any) st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.pend  <= '0;
            st_q.addr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !in_ready); // R2
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_mask)); // R11
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_mask & lead_oh) == lead_oh && lead_oh != '0); // R4
    AST_LAST_ENDS_WARP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid); // R10
    AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !tx_last |=> tx_valid && ((tx_mask & $past(tx_mask)) == '0)); // R12
endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [LANES*AW-1:0] in_addr = '0;
    logic [LANES-1:0] in_mask = '0;
    logic tx_valid;
    logic tx_ready = 1'b1;
    logic [AW-1:0] tx_base;
    logic [LANES-1:0] tx_mask;
    logic tx_last;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] a [LANES];

    always #4 clk = ~clk;

    warp_coalescer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_mask(in_mask), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_base(tx_base), .tx_mask(tx_mask), .tx_last(tx_last)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic present(logic [LANES-1:0] m);
        @(negedge clk);
        for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = a[i];
        in_mask  = m;
        in_valid = 1'b1;
        check("R2 idle ready before accept", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Sends one warp and checks every transaction against a model.
    task automatic run_warp(string tag, logic [LANES-1:0] m, int exp_n);
        logic [LANES-1:0] pend;
        logic [LANES-1:0] em;
        logic [LANES-1:0] seen;
        int lead;
        int n;
        present(m);
        pend = m;
        seen = '0;
        n = 0;
        while (pend != '0 && n < 40) begin
            lead = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
            em = '0;
            for (int j = 0; j < LANES; j++)
                if (pend[j] && a[j][AW-1:7] == a[lead][AW-1:7]) em[j] = 1'b1;
            check({tag, " R4 valid"}, 64'(tx_valid), 64'd1);
            check({tag, " R3 base"}, 64'(tx_base), 64'({a[lead][AW-1:7], 7'b0}));
            check({tag, " R4 R5 R6 mask"}, 64'(tx_mask), 64'(em));
            check({tag, " R10 last"}, 64'(tx_last), 64'((pend & ~em) == '0));
            check({tag, " R2 busy"}, 64'(in_ready), 64'd0);
            seen = seen | tx_mask;
            pend = pend & ~em;
            n++;
            @(negedge clk);
        end
        check({tag, " R12 union"}, 64'(seen), 64'(m));
        check({tag, " count"}, 64'(n), 64'(exp_n));
        check({tag, " R10 drained"}, 64'(tx_valid), 64'd0);
        check({tag, " R2 ready again"}, 64'(in_ready), 64'd1);
    endtask

    task automatic t_full_coalesce();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_2000 + 32'(i) * 4;
        run_warp("full32", '1, 1);
    endtask

    task automatic t_half_warp();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0001_0080 + 32'(i) * 4;
        run_warp("R8 half", 32'h0000_FFFF, 1);
    endtask

    task automatic t_row_stride();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0004_0000 + 32'(i) * 512;
        run_warp("R9 stride", '1, 32);
    endtask

    task automatic t_misaligned();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_3040 + 32'(i) * 4;
        run_warp("R3 straddle", '1, 2);
    endtask

    task automatic t_interleaved();
        for (int i = 0; i < LANES; i++) a[i] = 32'(i % 3) * 32'h1000 + 32'h0700 + 32'(i % 8) * 4;
        run_warp("R5 interleave", '1, 3);
    endtask

    task automatic t_inactive();
        for (int i = 0; i < LANES; i++) a[i] = (i % 2 == 0) ? 32'h0000_5000 + 32'(i) : 32'h0000_9000 + 32'(i) * 128;
        run_warp("R6 inactive", 32'h5555_5555, 1);
    endtask

    task automatic t_empty();
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_7000 + 32'(i) * 4;
        present('0);
        check("R7 no tx", 64'(tx_valid), 64'd0);
        check("R7 ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        check("R7 still no tx", 64'(tx_valid), 64'd0);
    endtask

    task automatic t_stall();
        logic [AW-1:0] b0;
        logic [LANES-1:0] m0;
        int n;
        for (int i = 0; i < LANES; i++) a[i] = (i < 16) ? 32'h0000_8000 + 32'(i) * 4 : 32'h0000_A000 + 32'(i) * 4;
        tx_ready = 1'b0;
        present('1);
        b0 = tx_base;
        m0 = tx_mask;
        for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = 32'hFFFF_0000;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        check("R11 valid held", 64'(tx_valid), 64'd1);
        check("R11 base held", 64'(tx_base), 64'(b0));
        check("R11 mask held", 64'(tx_mask), 64'(m0));
        check("R2 no accept while busy", 64'(tx_base), 64'h8000);
        tx_ready = 1'b1;
        n = 0;
        while (tx_valid && n < 40) begin
            n++;
            @(negedge clk);
        end
        check("R11 stall count", 64'(n), 64'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset tx_valid", 64'(tx_valid), 64'd0);
        check("R1 reset in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post reset tx_valid", 64'(tx_valid), 64'd0);
        t_full_coalesce();
        t_half_warp();
        t_row_stride();
        t_misaligned();
        t_interleaved();
        t_inactive();
        t_empty();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule